// File: doc/BRIEF.md
# Selective Hit Frame Serializer

This block drains converted hit data from a bank of capture channels onto one serial data wire. It runs on the readout clock, nominally 10 MHz. When readout is requested, it records which channels report a stored hit. It then walks those channels from the lowest number to the highest. For each one it shifts out a fixed frame that packs the channel number, the coarse timestamp, the charge code and the fine-time code. Channels that report nothing cost no line time at all.

A frame-valid output marks every bit that belongs to a frame. Frames of one pass follow each other with no idle cycle between them. As soon as a channel's frame has fully left the wire, the block raises a one-cycle release strobe for that channel. The capture logic uses the strobe to free its storage. Hits that arrive after the request wait for the next pass, because the set of channels to read is frozen when the request is taken.

Top module: `hitlink_readout`

## Requirements
- R1: After reset `sdata_o`, `fvalid_o` and every bit of `release_o` are 0.
- R2: Each frame is 52 bits, sent most significant bit first. Frame bits 51..48 carry the channel number, bits 47..24 the timestamp, bits 23..12 the charge code and bits 11..0 the fine-time code.
- R3: A pass sends exactly one frame for each channel whose `ready_i` bit was 1 in the cycle the request was accepted, and no frame for any other channel.
- R4: Frames of one pass go out in ascending channel order. They are back to back, so `fvalid_o` stays high without a break for 52 cycles per frame sent.
- R5: `fvalid_o` is 1 only while frame bits are on the wire, and `sdata_o` is 0 whenever `fvalid_o` is 0.
- R6: For each frame, `release_o` pulses for exactly one cycle, in the cycle right after that frame's last bit. The pulse is one-hot on the frame's channel, and `release_o` is 0 in all other cycles.
- R7: Changes to `ready_i` after a request has been accepted do not change the frames of the running pass. A later request picks those changes up.
- R8: A `start_i` pulse that arrives while a pass is running is ignored.
- R9: The first frame bit appears on the wire in the second cycle after the cycle in which `start_i` is sampled high.
- R10: A request taken while `ready_i` is all zero sends nothing. The block then accepts the next request.
- R11: A pass that reads all 16 channels finishes within 16*52+2 cycles of the request. At 10 MHz that is under 100 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Readout request; sampled only while idle |
| ready_i | input | 16 | Per-channel flag: this channel holds a converted hit |
| stamp_i | input | 384 | Per-channel 24-bit coarse timestamp, channel k at bits [24k+23:24k] |
| charge_i | input | 192 | Per-channel 12-bit charge code, channel k at bits [12k+11:12k] |
| fine_i | input | 192 | Per-channel 12-bit fine-time code, channel k at bits [12k+11:12k] |
| sdata_o | output | 1 | Serial frame data |
| fvalid_o | output | 1 | High during every frame bit |
| release_o | output | 16 | One-cycle per-channel strobe after that channel's frame |

## Verification
If the pending set is corrupted, frames go missing or extra frames appear in the sequence compared on the wire. It can also show up as a release strobe on the wrong channel. Either shows within one frame time of the fault. A bit counter that is off by one shifts every field of the frame. That breaks the very next 52-bit comparison and changes the measured length of the frame-valid window. A fault in the snapshot or in how idle is defined shows up within the same pass: a late ready bit or a repeated request turns into an extra frame.

// File: rtl/hr_pkg.sv
package hr_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } hr_state_t;

endpackage

// File: rtl/hr_pick.sv
module hr_pick #(
  parameter int N_CH  = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_CH-1:0]  pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // lowest pending channel wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/hr_shift.sv
module hr_shift #(
  parameter int FW = 52
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  output logic          sdata_o,
  output logic          fvalid_o,
  output logic          last_o
);

  localparam int CNT_W = $clog2(FW);

  logic [FW-1:0]    shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (load_i) begin
      shreg_q <= frame_i;
      cnt_q   <= CNT_W'(FW - 1);
      act_q   <= 1'b1;
    end else if (act_q) begin
      shreg_q <= {shreg_q[FW-2:0], 1'b0};
      if (cnt_q == '0) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign sdata_o  = shreg_q[FW-1];
  assign fvalid_o = act_q;
  assign last_o   = act_q && (cnt_q == '0);

  // R4
  load_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (!act_q || cnt_q == '0));

  // R2
  full_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> $past(cnt_q) == '0);

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !shreg_q[FW-1]);

endmodule

// File: rtl/hitlink_readout.sv
module hitlink_readout #(
  parameter int N_CH = 16,
  parameter int CH_W = 4,
  parameter int TS_W = 24,
  parameter int Q_W  = 12,
  parameter int FT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [N_CH-1:0]      ready_i,
  input  logic [N_CH*TS_W-1:0] stamp_i,
  input  logic [N_CH*Q_W-1:0]  charge_i,
  input  logic [N_CH*FT_W-1:0] fine_i,
  output logic                 sdata_o,
  output logic                 fvalid_o,
  output logic [N_CH-1:0]      release_o
);
  import hr_pkg::*;

  localparam int FW      = CH_W + TS_W + Q_W + FT_W;
  localparam int LAT_MAX = N_CH * FW + 2;
  localparam int LAT_W   = $clog2(LAT_MAX + 2) + 1;

  hr_state_t        state_q;
  logic [N_CH-1:0]  snap_q;
  logic [N_CH-1:0]  pend_q;
  logic [CH_W-1:0]  cur_q;
  logic [N_CH-1:0]  rel_q;
  logic [LAT_W-1:0] lat_q;

  logic             any_w;
  logic [CH_W-1:0]  idx_w;
  logic             last_w;
  logic             act_w;
  logic             free_w;
  logic             take_w;
  logic [FW-1:0]    frame_w;
  logic [FW-1:0]    frm_arr [N_CH];

  hr_pick #(.N_CH(N_CH), .IDX_W(CH_W)) u_pick (
    .pend_i (pend_q),
    .any_o  (any_w),
    .idx_o  (idx_w)
  );

  // per-channel frame assembly
  for (genvar g = 0; g < N_CH; g++) begin : g_frm
    assign frm_arr[g] = {CH_W'(g),
                         stamp_i[g*TS_W +: TS_W],
                         charge_i[g*Q_W +: Q_W],
                         fine_i[g*FT_W +: FT_W]};
  end

  assign frame_w = frm_arr[idx_w];
  assign free_w  = !act_w || last_w;
  assign take_w  = (state_q == ST_RUN) && any_w && free_w;

  hr_shift #(.FW(FW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load_i   (take_w),
    .frame_i  (frame_w),
    .sdata_o  (sdata_o),
    .fvalid_o (act_w),
    .last_o   (last_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      snap_q  <= '0;
      pend_q  <= '0;
      cur_q   <= '0;
      rel_q   <= '0;
      lat_q   <= '0;
    end else begin
      rel_q <= last_w ? (N_CH'(1) << cur_q) : '0;
      case (state_q)
        ST_IDLE: begin
          lat_q <= '0;
          if (start_i) begin
            snap_q  <= ready_i;
            pend_q  <= ready_i;
            state_q <= ST_RUN;
          end
        end
        default: begin
          lat_q <= lat_q + 1'b1;
          if (take_w) begin
            pend_q[idx_w] <= 1'b0;
            cur_q         <= idx_w;
          end
          if (!any_w && free_w) begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign fvalid_o  = act_w;
  assign release_o = rel_q;

  // R5
  valid_in_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !act_w);

  // R6
  rel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rel_q));

  // R6
  rel_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_q != '0) |-> $past(last_w));

  // R3
  rel_in_snap_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_q & ~snap_q) == '0);

  // R7
  pend_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~snap_q) == '0);

  // R11
  pass_time_chk: assert property (@(posedge clk) disable iff (rst)
    lat_q <= LAT_W'(LAT_MAX));

endmodule

// File: tb/hitlink_readout_test.sv
module hitlink_readout_test;

  localparam int N    = 16;
  localparam int FW   = 52;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [N-1:0]  ready_i = '0;
  logic [N*24-1:0] stamp_i = '0;
  logic [N*12-1:0] charge_i = '0;
  logic [N*12-1:0] fine_i = '0;
  logic          sdata_o;
  logic          fvalid_o;
  logic [N-1:0]  release_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [FW-1:0] exp_q [$];

  hitlink_readout uut (
    .clk(clk), .rst(rst), .start_i(start_i), .ready_i(ready_i),
    .stamp_i(stamp_i), .charge_i(charge_i), .fine_i(fine_i),
    .sdata_o(sdata_o), .fvalid_o(fvalid_o), .release_o(release_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: assemble frames, compare with scoreboard, check release strobes
  logic [FW-1:0] acc = '0;
  int            nbit = 0;
  bit            rel_due = 1'b0;
  logic [3:0]    rel_ch = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rel_due) begin
        // R6 strobe for the frame that just ended
        check(release_o == (N'(1) << rel_ch), "R6", 64'(release_o), 64'(N'(1) << rel_ch));
      end else if (release_o != '0) begin
        check(1'b0, "R6", 64'(release_o), 64'h0);
      end
      rel_due = 1'b0;
      if (fvalid_o) begin
        acc = {acc[FW-2:0], sdata_o};
        nbit++;
        if (nbit == FW) begin
          nbit = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", 64'(acc), 64'h0);
          end else begin
            logic [FW-1:0] e;
            e = exp_q.pop_front();
            // R2 field layout, R3 selection, R4 order
            check(acc == e, "R2/R3 frame", 64'(acc), 64'(e));
          end
          rel_due = 1'b1;
          rel_ch  = acc[FW-1 -: 4];
        end
      end else if (sdata_o !== 1'b0) begin
        check(1'b0, "R5", 64'(sdata_o), 64'h0);
      end
    end
  end

  task automatic fill_fields();
    for (int i = 0; i < N; i++) begin
      stamp_i[i*24 +: 24]  = 24'($urandom);
      charge_i[i*12 +: 12] = 12'($urandom);
      fine_i[i*12 +: 12]   = 12'($urandom);
    end
  endtask

  // driver: push expected frames, issue request, time the valid window
  task automatic run_pass(input logic [N-1:0] mask, input logic [N-1:0] late, input bit dup_start);
    int nf = 0;
    int run = 0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        exp_q.push_back({4'(i), stamp_i[i*24 +: 24], charge_i[i*12 +: 12], fine_i[i*12 +: 12]});
        nf++;
      end
    end
    @(negedge clk);
    ready_i = mask;
    start_i = 1'b1;
    @(negedge clk);
    start_i = dup_start;
    ready_i = late;                       // R7 late change
    check(fvalid_o == 1'b0, "R9 early", 64'(fvalid_o), 64'h0);
    @(negedge clk);
    start_i = 1'b0;                       // R8 duplicate request just sampled
    check(fvalid_o == (nf != 0), "R9/R10 first bit", 64'(fvalid_o), 64'(nf != 0));
    while (fvalid_o) begin
      run++;
      @(negedge clk);
    end
    // R4 back-to-back; R11 bound when nf is 16
    check(run == nf * FW, "R4/R11 window", 64'(run), 64'(nf * FW));
    repeat (4) @(negedge clk);
    check(fvalid_o == 1'b0, "R8/R10 idle after pass", 64'(fvalid_o), 64'h0);
    check(exp_q.size() == 0, "R3 all frames seen", 64'(exp_q.size()), 64'h0);
    ready_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check(sdata_o == 1'b0 && fvalid_o == 1'b0 && release_o == '0, "R1 reset",
          {62'(release_o), fvalid_o, sdata_o}, 64'h0);
    fill_fields();
    run_pass(16'h0001, '0, 1'b0);
    run_pass(16'h8000, '0, 1'b0);
    fill_fields();
    run_pass(16'hA5A5, 16'hFFFF, 1'b1);   // R7 and R8
    run_pass(16'h0000, 16'hFFFF, 1'b1);   // R10
    fill_fields();
    run_pass(16'hFFFF, '0, 1'b1);         // R11 full pass
    run_pass(16'h0240, '0, 1'b0);         // R7 late hits read next time
    fill_fields();
    run_pass(16'h7FFE, 16'h0001, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule